// File: doc/BRIEF.md
# Radix-4 Booth Sequential Multiplier

This block multiplies two 32-bit integers over several clock cycles. It leaves the 64-bit product in a pair of result registers: HI holds the upper word and LO holds the lower word. A one-cycle start request carries both operands and a flag that selects signed or unsigned operation. The block accepts the request only when it is idle. While it iterates it holds `busy` high. It then raises `done` for one cycle, and in that cycle the product is already visible on the read ports.

Each iteration retires two multiplier bits. The multiplier is loaded into LO and is shifted out of it. A recoder looks at the two lowest LO bits and at the bit most recently shifted out, and from these picks one of zero, plus or minus one times the multiplicand, or plus or minus two times the multiplicand. That amount is added into a 34-bit HI accumulator. The multiplicand is sign-extended for signed operation and zero-extended for unsigned operation. Unsigned operation needs one extra add-only step, which covers the multiplier's top bit.

When the block is idle, software-visible moves can write HI and LO directly. The two read ports show the registers at all times.

Top module: `booth4_mul`

## Requirements
- R1: With `mul_signed`=1, the block returns the two's-complement product of `opnd_a` and `opnd_b`, with bits 63:32 on `hi_rd` and bits 31:0 on `lo_rd`. This includes the most negative value multiplied by itself.
- R2: With `mul_signed`=0, the block returns the unsigned 64-bit product, split across `hi_rd` and `lo_rd` in the same way. This includes all-ones multiplied by all-ones.
- R3: After a start is accepted at a clock edge, `busy` is high for exactly 16 cycles for a signed request and exactly 17 cycles for an unsigned request.
- R4: `done` is high for exactly one cycle. That cycle is the first cycle after `busy` falls, and the final product is on the read ports during it.
- R5: A start request made while `busy` is high is ignored. The running product and its timing are unchanged.
- R6: While idle and with no start request, `hi_wr` loads `wr_data` into HI and `lo_wr` loads `wr_data` into LO. Each write is visible on the read port one cycle later, and the two writes are independent.
- R7: Write requests made while `busy` is high, or in the same cycle as an accepted start, have no effect. The start takes priority.
- R8: When idle with no start and no write request, HI and LO keep their values, including a finished product.
- R9: After reset, `busy`=0, `done`=0, `hi_rd`=0 and `lo_rd`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mul_start | input | 1 | Start request; accepted only while idle |
| mul_signed | input | 1 | 1 = signed operands, 0 = unsigned operands |
| opnd_a | input | 32 | Multiplicand |
| opnd_b | input | 32 | Multiplier |
| hi_wr | input | 1 | Direct write of HI from wr_data |
| lo_wr | input | 1 | Direct write of LO from wr_data |
| wr_data | input | 32 | Data for direct writes |
| busy | output | 1 | Iteration in progress |
| done | output | 1 | One-cycle pulse when the product is complete |
| hi_rd | output | 32 | HI register (upper product word) |
| lo_rd | output | 32 | LO register (lower product word) |

## Verification
The bench targets the operand patterns that stress the recoder:
- The most negative value squared and minus one times minus one. A design that sized the accumulator too narrowly or extended the multiplicand wrongly returns a wrapped upper word.
- Alternating-bit multipliers, which produce a long run of plus-two and minus-two digits.
- All-ones unsigned operands. These catch a missing or wrongly weighted extra step, because a design that skips it gives a product short by the multiplicand times 2^32.

Start requests and writes are also injected while busy, including in the final busy cycle and together with an accepted start. A design that restarts, or that lets a write reach the registers, shows a wrong product or a stretched busy window.

// File: rtl/booth4_pkg.sv
package booth4_pkg;

  // Selection produced by the radix-4 recoder for one digit.
  typedef struct packed {
    logic act;  // add or subtract something at all
    logic neg;  // subtract instead of add
    logic dbl;  // use twice the multiplicand
  } booth_sel_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_TAIL = 2'd2
  } run_state_t;

  // Window is {upper bit, lower bit, previously shifted-out bit}.
  function automatic booth_sel_t booth_recode(input logic [2:0] win);
    booth_sel_t s;
    case (win)
      3'b001, 3'b010: s = '{act: 1'b1, neg: 1'b0, dbl: 1'b0};
      3'b011:         s = '{act: 1'b1, neg: 1'b0, dbl: 1'b1};
      3'b100:         s = '{act: 1'b1, neg: 1'b1, dbl: 1'b1};
      3'b101, 3'b110: s = '{act: 1'b1, neg: 1'b1, dbl: 1'b0};
      default:        s = '{act: 1'b0, neg: 1'b0, dbl: 1'b0};
    endcase
    return s;
  endfunction

endpackage

// File: rtl/booth4_recoder.sv
module booth4_recoder
  import booth4_pkg::*;
(
  input  logic [2:0]  win,
  output booth_sel_t  sel
);

  assign sel = booth_recode(win);

endmodule

// File: rtl/booth4_addsub.sv
module booth4_addsub
  import booth4_pkg::*;
#(
  parameter int AW = 34
) (
  input  logic [AW-1:0] acc,
  input  logic [AW-1:0] mcand,
  input  booth_sel_t    sel,
  output logic [AW-1:0] sum
);

  function automatic logic [AW-1:0] booth_accum(input logic [AW-1:0] a,
                                                input logic [AW-1:0] m,
                                                input booth_sel_t    s);
    logic [AW-1:0] term;
    term = s.dbl ? {m[AW-2:0], 1'b0} : m;
    if (!s.act) return a;
    return s.neg ? (a - term) : (a + term);
  endfunction

  assign sum = booth_accum(acc, mcand, sel);

endmodule

// File: rtl/booth4_ctrl.sv
module booth4_ctrl
  import booth4_pkg::*;
#(
  parameter int STEPS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic sgn,
  output logic busy,
  output logic done,
  output logic load,
  output logic step,
  output logic tail
);

  localparam int CW = $clog2(STEPS + 1);

  run_state_t    st_q;
  logic [CW-1:0] cnt_q;
  logic          sgn_q;
  logic          done_q;
  logic [CW:0]   span_q;   // busy cycles of the current run, for checking
  logic          last_run;

  assign load     = (st_q == ST_IDLE) && start;
  assign step     = (st_q == ST_RUN);
  assign tail     = (st_q == ST_TAIL);
  assign last_run = step && (cnt_q == CW'(STEPS - 1));
  assign busy     = (st_q != ST_IDLE);
  assign done     = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      sgn_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= (last_run && sgn_q) || tail;
      case (st_q)
        ST_IDLE: begin
          if (start) begin
            st_q  <= ST_RUN;
            cnt_q <= '0;
            sgn_q <= sgn;
          end
        end
        ST_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (last_run) st_q <= sgn_q ? ST_IDLE : ST_TAIL;
        end
        ST_TAIL: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     span_q <= '0;
    else if (load)  span_q <= '0;
    else if (busy)  span_q <= span_q + 1'b1;
  end

  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done held longer than one cycle");

  assert_done_follows_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done) else $error("busy fell without done");

  assert_no_busy_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done)) else $error("busy and done together");

  assert_run_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (span_q == (sgn_q ? (CW+1)'(STEPS) : (CW+1)'(STEPS + 1))))
    else $error("wrong number of busy cycles");

endmodule

// File: rtl/booth4_mul.sv
module booth4_mul
  import booth4_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mul_start,
  input  logic         mul_signed,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic         hi_wr,
  input  logic         lo_wr,
  input  logic [W-1:0] wr_data,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] hi_rd,
  output logic [W-1:0] lo_rd
);

  localparam int AW    = W + 2;
  localparam int STEPS = W / 2;

  function automatic logic [AW-1:0] extend_mcand(input logic [W-1:0] v,
                                                 input logic       s);
    return s ? {{2{v[W-1]}}, v} : {2'b00, v};
  endfunction

  logic [AW-1:0] hi_q;
  logic [AW-1:0] mc_q;
  logic [W-1:0]  lo_q;
  logic          prev_q;

  logic          load, step, tail;
  logic [2:0]    win;
  booth_sel_t    sel;
  logic [AW-1:0] sum;

  booth4_ctrl #(.STEPS(STEPS)) ctrl_i (
    .clk   (clk),
    .rst_n (rst_n),
    .start (mul_start),
    .sgn   (mul_signed),
    .busy  (busy),
    .done  (done),
    .load  (load),
    .step  (step),
    .tail  (tail)
  );

  // The extra unsigned step sees zero multiplier bits above bit W-1.
  assign win = tail ? {2'b00, prev_q} : {lo_q[1:0], prev_q};

  booth4_recoder rec_i (
    .win (win),
    .sel (sel)
  );

  booth4_addsub #(.AW(AW)) alu_i (
    .acc   (hi_q),
    .mcand (mc_q),
    .sel   (sel),
    .sum   (sum)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      lo_q   <= '0;
      mc_q   <= '0;
      prev_q <= 1'b0;
    end else if (load) begin
      mc_q   <= extend_mcand(opnd_a, mul_signed);
      hi_q   <= '0;
      lo_q   <= opnd_b;
      prev_q <= 1'b0;
    end else if (step) begin
      hi_q   <= {{2{sum[AW-1]}}, sum[AW-1:2]};
      lo_q   <= {sum[1:0], lo_q[W-1:2]};
      prev_q <= lo_q[1];
    end else if (tail) begin
      hi_q   <= sum;
    end else begin
      if (hi_wr) hi_q <= {2'b00, wr_data};
      if (lo_wr) lo_q <= wr_data;
    end
  end

  assign hi_rd = hi_q[W-1:0];
  assign lo_rd = lo_q;

  assert_start_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mul_start) |=> $stable(mc_q)) else $error("start accepted while busy");

  assert_write_hi_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !mul_start && hi_wr) |=> (hi_rd == $past(wr_data)))
    else $error("HI write lost");

  assert_write_lo_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !mul_start && lo_wr) |=> (lo_rd == $past(wr_data)))
    else $error("LO write lost");

  assert_start_beats_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && mul_start) |=> (hi_q == '0 && lo_rd == $past(opnd_b)))
    else $error("write won over start");

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !mul_start && !hi_wr && !lo_wr) |=> ($stable(hi_rd) && $stable(lo_rd)))
    else $error("idle registers changed");

  assert_tail_adds_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tail |-> (!sel.neg && !sel.dbl)) else $error("extra step subtracted or doubled");

endmodule

// File: tb/booth4_mul_tb_top.sv
module booth4_mul_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, sg = 1'b0, hi_wr = 1'b0, lo_wr = 1'b0;
  logic [31:0] opa = '0, opb = '0, wr_data = '0;
  logic        busy, done;
  logic [31:0] hi_rd, lo_rd;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  booth4_mul dut_i (
    .clk(clk), .rst_n(rst_n), .mul_start(start), .mul_signed(sg),
    .opnd_a(opa), .opnd_b(opb), .hi_wr(hi_wr), .lo_wr(lo_wr),
    .wr_data(wr_data), .busy(busy), .done(done), .hi_rd(hi_rd), .lo_rd(lo_rd)
  );

  function automatic logic [63:0] ref_product(input logic [31:0] a,
                                              input logic [31:0] b,
                                              input logic        s);
    longint sa, sb;
    if (s) begin
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      return 64'(sa * sb);
    end
    return {32'b0, a} * {32'b0, b};
  endfunction

  task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model, advanced on every rising edge.
  logic        m_busy = 1'b0, m_done = 1'b0;
  logic [31:0] m_hi = '0, m_lo = '0;
  logic [63:0] m_res = '0;
  int          m_rem = 0;
  string       m_tag = "R9";
  string       run_tag = "R1";

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 1'b0; m_done = 1'b0; m_hi = '0; m_lo = '0; m_rem = 0; m_tag = "R9";
    end else begin
      m_done = 1'b0;
      if (m_busy) begin
        if (start) run_tag = "R5";
        if (hi_wr || lo_wr) run_tag = "R7";
        if (m_rem == 1) begin
          m_busy = 1'b0; m_done = 1'b1;
          {m_hi, m_lo} = m_res;
          m_tag = run_tag;
        end else begin
          m_rem--;
        end
      end else if (start) begin
        m_busy  = 1'b1;
        m_rem   = sg ? 16 : 17;
        m_res   = ref_product(opa, opb, sg);
        run_tag = (hi_wr || lo_wr) ? "R7" : (sg ? "R1" : "R2");
      end else begin
        if (hi_wr) begin m_hi = wr_data; m_tag = "R6"; end
        if (lo_wr) begin m_lo = wr_data; m_tag = "R6"; end
        if (!hi_wr && !lo_wr && (m_tag == "R1" || m_tag == "R2")) m_tag = "R8";
      end
    end
  end

  // Compare on every falling edge once reset is released.
  always @(negedge clk) begin
    if (rst_n) begin
      check64("R3 busy", {63'b0, busy}, {63'b0, m_busy});
      check64("R4 done", {63'b0, done}, {63'b0, m_done});
      if (!m_busy) check64(m_tag, {hi_rd, lo_rd}, {m_hi, m_lo});
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic write_regs(input logic h, input logic l, input logic [31:0] d);
    @(negedge clk); #1;
    hi_wr = h; lo_wr = l; wr_data = d;
    @(negedge clk); #1;
    hi_wr = 1'b0; lo_wr = 1'b0;
  endtask

  task automatic run_mul(input logic [31:0] a, input logic [31:0] b, input logic s,
                         input int poke_start, input int poke_wr, input logic wr_with_start);
    @(negedge clk); #1;
    start = 1'b1; sg = s; opa = a; opb = b;
    hi_wr = wr_with_start; lo_wr = wr_with_start; wr_data = 32'hDEAD_BEEF;
    @(negedge clk); #1;
    start = 1'b0; hi_wr = 1'b0; lo_wr = 1'b0;
    for (int k = 1; k <= 20; k++) begin
      start = (k == poke_start);
      if (k == poke_start) begin opa = ~a; opb = b + 32'd3; sg = ~s; end
      hi_wr = (k == poke_wr); lo_wr = (k == poke_wr);
      wr_data = 32'h0BAD_F00D;
      @(negedge clk); #1;
    end
    start = 1'b0; hi_wr = 1'b0; lo_wr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state seen at the ports while reset is held
    check64("R9", {62'b0, busy, done}, 64'd0);
    check64("R9", {hi_rd, lo_rd}, 64'd0);
    #1 rst_n = 1'b1;
    idle(2);

    // R6: independent direct writes, then R8 hold
    write_regs(1'b1, 1'b0, 32'h1234_5678);
    write_regs(1'b0, 1'b1, 32'h9ABC_DEF0);
    write_regs(1'b1, 1'b1, 32'h0F0F_0F0F);
    idle(3);

    // R1: signed corner operands
    run_mul(32'h8000_0000, 32'h8000_0000, 1'b1, -1, -1, 1'b0);
    run_mul(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, -1, -1, 1'b0);
    run_mul(32'h7FFF_FFFF, 32'h8000_0000, 1'b1, -1, -1, 1'b0);
    run_mul(32'h0000_0000, 32'h1234_5678, 1'b1, -1, -1, 1'b0);
    run_mul(32'hAAAA_AAAA, 32'h5555_5555, 1'b1, -1, -1, 1'b0);
    run_mul(32'h1234_5678, 32'hAAAA_AAAA, 1'b1, -1, -1, 1'b0);
    // R2: unsigned corner operands
    run_mul(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, -1, -1, 1'b0);
    run_mul(32'h8000_0000, 32'h8000_0000, 1'b0, -1, -1, 1'b0);
    run_mul(32'hAAAA_AAAA, 32'h5555_5555, 1'b0, -1, -1, 1'b0);
    run_mul(32'hFFFF_FFFF, 32'h0000_0001, 1'b0, -1, -1, 1'b0);
    idle(4);  // R8: finished product held

    // R5: start requests while busy, including the final busy cycle
    run_mul(32'h0001_2345, 32'hFFFF_0001, 1'b1, 3, -1, 1'b0);
    run_mul(32'hC000_0001, 32'h8765_4321, 1'b1, 16, -1, 1'b0);
    run_mul(32'hC000_0001, 32'h8765_4321, 1'b0, 17, -1, 1'b0);
    // R7: writes while busy and together with an accepted start
    run_mul(32'h7654_3210, 32'hFEDC_BA98, 1'b0, -1, 5, 1'b0);
    run_mul(32'h7654_3210, 32'hFEDC_BA98, 1'b1, -1, 16, 1'b1);
    idle(2);

    // R1/R2: mixed random operands
    for (int n = 0; n < 60; n++) begin
      run_mul($urandom, $urandom, 1'($urandom), -1, -1, 1'b0);
    end
    idle(3);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule